// File: doc/BRIEF.md
# Whole-Vector Right Shifter

This combinational unit shifts a 128-bit data vector `a` to the right as one quantity. A 2-bit operation code selects the form of the shift. The bit form moves the whole vector right by 0 to 7 bit positions. The octet form moves it right by 0 to 15 whole bytes. The byte-variable form gives each result byte its own 0 to 7 bit shift, and that byte takes its vacated high bits from the data byte above it.

A count vector `b` supplies the shift amounts for every operation. Bytes are numbered big-endian: byte 0 is `a[127:120]` and byte 15 is `a[7:0]`. Bits inside a byte are numbered MSB first.

In the bit form the count is meant to be copied into every byte of `b`. The unit always takes the count from the least-significant byte. When the bytes disagree, it raises a debug flag.

Top module: `vec_rshift`

## Requirements
- R1: With `op`=0 the result is `a` logically shifted right by `b[2:0]` bits, and zeros enter at the top.
- R2: With `op`=0 only `b[2:0]` sets the result. All other bits of `b` have no effect on `res`.
- R3: With `op`=0, `cnt_mismatch` is 1 exactly when the low three bits of some byte of `b` differ from `b[2:0]`.
- R4: With `op`=1 the result is `a` shifted right by `b[6:3]` whole bytes, and zero bytes enter at the top. Bits `b[2:0]`, `b[7]` and the upper 15 bytes of `b` are ignored.
- R5: With `op`=2, result byte i is the low byte of the 16-bit pair {byte i-1 of `a`, byte i of `a`} shifted right by the low three bits of byte i of `b`.
- R6: With `op`=2, byte 0 pairs with an all-zero byte above it, so only zeros enter result byte 0.
- R7: With `op`=3 the result is all zeros.
- R8: `cnt_mismatch` is 0 whenever `op` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 128 | Data vector, byte 0 in bits [127:120] |
| b | input | 128 | Count vector |
| op | input | 2 | Operation: 0 bit, 1 octet, 2 byte-variable, 3 zero |
| res | output | 128 | Shifted result |
| cnt_mismatch | output | 1 | Bit-mode count bytes are not all equal |

## Verification
The bench aims at the maximum counts: 7 bits, 15 octets and a per-byte 7. A wrong shift width or an off-by-one slice would leave stray data bits at the top there.

It sets the octet-mode bits of `b` that must be ignored, bit 7 and bits [2:0]. A design that decoded the wrong field would shift by the wrong number of bytes.

In byte-variable mode it checks that byte 0 fills with zeros, and that every other byte fills from its upper neighbour and not from the byte below. A swapped pair order would show up as garbage in the high bits.

It also breaks the replication in a single byte of `b`, so a flag that compared only some of the bytes stays low when it must rise.

// File: rtl/vec_rshift.sv
module vec_rshift #(
  parameter int NBYTES = 16
) (
  input  logic [NBYTES*8-1:0] a,
  input  logic [NBYTES*8-1:0] b,
  input  logic [1:0]          op,
  output logic [NBYTES*8-1:0] res,
  output logic                cnt_mismatch
);
  localparam int W  = NBYTES * 8;
  localparam int OW = $clog2(NBYTES);

  logic [W-1:0]      bit_res, oct_res, bv_res;
  logic [NBYTES-1:0] diff;
  logic [OW-1:0]     oct_cnt;
  logic              unused_bits;

  assign unused_bits = ^b;
  assign oct_cnt     = b[3 +: OW];
  assign bit_res     = a >> b[2:0];
  assign oct_res     = a >> {oct_cnt, 3'b000};

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int LO = W - 8 * (i + 1);
    logic [7:0]  upper;
    logic [15:0] pair;
    if (i == 0) begin : g_first
      assign upper = 8'h00;
    end else begin : g_rest
      assign upper = a[LO + 8 +: 8];
    end
    assign pair = {upper, a[LO +: 8]} >> b[LO +: 3];
    assign bv_res[LO +: 8] = pair[7:0];
    assign diff[i] = b[LO +: 3] != b[2:0];
  end

  always_comb begin
    case (op)
      2'd0:    res = bit_res;
      2'd1:    res = oct_res;
      2'd2:    res = bv_res;
      default: res = '0;
    endcase
  end

  assign cnt_mismatch = (op == 2'd0) && (|diff);
endmodule

// File: rtl/vec_rshift_chk.sv
module vec_rshift_chk #(
  parameter int NBYTES = 16
) (
  input logic [NBYTES*8-1:0] a,
  input logic [NBYTES*8-1:0] b,
  input logic [1:0]          op,
  input logic [NBYTES*8-1:0] res,
  input logic                cnt_mismatch
);
  localparam int W = NBYTES * 8;

  always_comb begin
    if (op == 2'd3)
      a_r7_zero_op: assert (res == '0);
    if (op != 2'd0)
      a_r8_flag_quiet: assert (!cnt_mismatch);
    if (op == 2'd0)
      a_r1_top_zero: assert ((res >> (W - int'(b[2:0]))) == '0);
    if (op == 2'd0 && b[2:0] == 3'd0)
      a_r2_zero_count: assert (res == a);
    if (op == 2'd1)
      a_r4_top_bytes_zero: assert ((res >> (W - 8 * int'(b[6:3]))) == '0);
    if (op == 2'd2 && b == '0)
      a_r5_bv_identity: assert (res == a);
    if (op == 2'd2 && b[W-8 +: 3] == 3'd7)
      a_r6_head_fill: assert (res[W-1 -: 7] == 7'd0);
  end
endmodule

bind vec_rshift vec_rshift_chk #(.NBYTES(NBYTES)) u_chk (
  .a(a), .b(b), .op(op), .res(res), .cnt_mismatch(cnt_mismatch)
);

// File: tb/sim_vec_rshift.sv
module sim_vec_rshift;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic [127:0] a, b, res;
  logic [1:0]   op;
  logic         cnt_mismatch;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_rshift u0 (.a(a), .b(b), .op(op), .res(res), .cnt_mismatch(cnt_mismatch));

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [127:0] rep(input logic [7:0] x);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = x;
    return r;
  endfunction

  function automatic logic [127:0] ref_bit(input logic [127:0] x, input int n);
    logic [127:0] r;
    for (int j = 0; j < 128; j++) r[127-j] = (j >= n) ? x[127-(j-n)] : 1'b0;
    return r;
  endfunction

  function automatic logic [127:0] ref_oct(input logic [127:0] x, input int k);
    logic [127:0] r;
    for (int j = 0; j < 16; j++)
      r[120-8*j +: 8] = (j >= k) ? x[120-8*(j-k) +: 8] : 8'h00;
    return r;
  endfunction

  function automatic logic [127:0] ref_bv(input logic [127:0] x, input logic [127:0] c);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      logic [7:0]  up;
      logic [15:0] t;
      up = (i == 0) ? 8'h00 : x[120-8*(i-1) +: 8];
      t  = {up, x[120-8*i +: 8]} >> c[120-8*i +: 3];
      r[120-8*i +: 8] = t[7:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_all(input logic [127:0] x, input logic [127:0] c,
                                           input logic [1:0] o);
    case (o)
      2'd0:    return ref_bit(x, int'(c[2:0]));
      2'd1:    return ref_oct(x, int'(c[6:3]));
      2'd2:    return ref_bv(x, c);
      default: return '0;
    endcase
  endfunction

  function automatic logic ref_flag(input logic [127:0] c, input logic [1:0] o);
    logic m = 1'b0;
    for (int i = 0; i < 16; i++) if (c[8*i +: 3] != c[2:0]) m = 1'b1;
    return (o == 2'd0) && m;
  endfunction

  task automatic apply(input string req, input logic [127:0] x, input logic [127:0] c,
                       input logic [1:0] o);
    logic [127:0] er;
    logic         ef;
    @(posedge clk);
    a = x; b = c; op = o;
    @(negedge clk);
    er = ref_all(x, c, o);
    ef = ref_flag(c, o);
    total++;
    if (res !== er || cnt_mismatch !== ef) begin
      bad++;
      $display("FAIL %s op=%0d res=%h flag=%b expected res=%h flag=%b", req, o, res,
               cnt_mismatch, er, ef);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] x, c;
    void'($urandom(32'd1234));
    a = '0; b = '0; op = 2'd3;
    // R7: all-zero code, initial state
    apply("R7", '1, '1, 2'd3);
    // R1: maximum bit count, zeros at the top
    apply("R1", '1, rep(8'h07), 2'd0);
    apply("R1", 128'h8000_0000_0000_0000_0000_0000_0000_0001, rep(8'h03), 2'd0);
    // R2: high bits of each count byte are set but must not matter
    apply("R2", 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, rep(8'hfd), 2'd0);
    // R3: replication broken in one byte only
    apply("R3", rnd128(), {8'h04, {15{8'h05}}}, 2'd0);
    apply("R3", rnd128(), {{15{8'h02}}, 8'h0a}, 2'd0);
    // R4: octet count 15, with ignored bits 7 and [2:0] set
    apply("R4", '1, {120'h0, 8'hff}, 2'd1);
    apply("R4", 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff, {120'h5a5a, 8'h9f}, 2'd1);
    // R8: flag stays low in other modes even with a scrambled count
    apply("R8", rnd128(), {8'h01, {15{8'h06}}}, 2'd1);
    // R5: byte-variable, every byte shifted by 7, fills from the byte above
    apply("R5", 128'h0102_0408_1020_4080_ff00_ff00_aa55_aa55, rep(8'h07), 2'd2);
    // R6: byte 0 takes zeros from above
    apply("R6", '1, {8'h07, 120'h0}, 2'd2);
    // R8 with byte-variable and mismatched bytes
    apply("R8", rnd128(), {8'h03, {15{8'h01}}}, 2'd2);
    for (int n = 0; n < 600; n++) begin
      x = rnd128();
      c = ($urandom() % 2 == 0) ? rep(8'($urandom())) : rnd128();
      case (n % 4)
        0: apply("R1", x, c, 2'd0);
        1: apply("R4", x, c, 2'd1);
        2: apply("R5", x, c, 2'd2);
        default: apply("R7", x, c, 2'd3);
      endcase
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule